// File: doc/BRIEF.md
# Byte-Lane Configurable Parallel Port

This block is a wide parallel I/O port cut into independent byte lanes, six of eight bits by default. Each lane is set to either receive or drive. It has its own data polarity, and it can be taken off the pins in two ways: by an internal tri-state bit held in its configuration, or by a dedicated external per-lane tri-state pin. The pads appear as three separate buses: the level seen at each pin, the value to drive and the output enable. The pull-up resistors on the board are outside the block.

A host writes one lane at a time. Each write sets the lane's direction, its polarity, its internal tri-state bit and its output value together. The host reads all lanes at once as a single wide word, with the highest lane in the most significant byte. Pin levels pass through a two-stage synchronizer before they reach the read word. An input lane set to active low returns its pins inverted. An output lane returns the level actually present on its pins.

Top module: `pio_port`

## Requirements
- R1: After reset, every lane is an active-high input with internal tri-state set and an output value of zero, so pad_oe is all zeros. Once two clock edges have passed with undriven, pulled-up pins, rd_data reads all ones.
- R2: A write with cfg_we high and cfg_lane equal to lane L changes only lane L. The new mode and value take effect at the rising edge that samples the write, and not before it.
- R3: A lane set as an output, with internal tri-state clear and its ext_tri bit low, drives all eight pad_oe bits high. Its pad_out byte equals the loaded value when active high (cfg_act_low=0) and its bitwise inverse when active low (cfg_act_low=1).
- R4: An output lane with its internal tri-state bit set (cfg_int_tri=1) drives all its pad_oe bits low.
- R5: While ext_tri[L] is high, all pad_oe bits of lane L are low, whatever the lane's configuration. The change appears combinationally, without waiting for a clock edge.
- R6: A lane set as an input (cfg_dir_out=0) never drives its pad_oe bits high.
- R7: rd_data bits [8L+7:8L] carry lane L, so lane 5 is the most significant byte. An input lane that is active low returns its synchronized pin levels inverted. Every other lane returns its synchronized pin levels unchanged.
- R8: A change on pad_in shows up on rd_data after exactly two rising clock edges. After one edge, rd_data still shows the old value.
- R9: A write whose cfg_lane is 6 or 7 (not a lane that exists) changes no lane's output value, mode or output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lane | input | 3 | Lane selected by the write |
| cfg_dir_out | input | 1 | 1 makes the lane an output, 0 an input |
| cfg_act_low | input | 1 | 1 selects active-low data for the lane |
| cfg_int_tri | input | 1 | 1 places the lane's outputs in tri-state |
| cfg_wdata | input | 8 | Output value loaded into the lane |
| ext_tri | input | 6 | External tri-state, one bit per lane |
| pad_in | input | 48 | Level present at each pin |
| pad_out | output | 48 | Value to drive at each pin |
| pad_oe | output | 48 | Output enable for each pin |
| rd_data | output | 48 | Read word for all lanes, lane 5 in the top byte |

## Verification
The bench applies a far-side driver and models the pull-ups, so a lane that wrongly drives its pins, or wrongly releases them, changes the level read back. A design that ignored either tri-state source would keep driving and hide the pulled-up ones. An active-low read that was not inverted on input lanes, or was also inverted on output lanes, would return the complement of the expected byte. A synchronizer one stage short or one stage long fails the check that the old value still shows one edge after a pin change. Writes to lane numbers 6 and 7 are aimed at designs that decode the lane index too loosely: such a design would alias those writes onto a real lane and change its drive.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef struct packed {
      logic dir_out;
      logic act_low;
      logic int_tri;
   } lane_mode_t;

   localparam lane_mode_t MODE_RESET = '{dir_out: 1'b0, act_low: 1'b0, int_tri: 1'b1};

endpackage

// File: rtl/pio_lane_reg.sv
module pio_lane_reg
   import pio_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int IDX_W   = 3,
   parameter int LANE_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_lane,
   input  lane_mode_t        cfg_mode,
   input  logic [LANE_W-1:0] cfg_wdata,
   output lane_mode_t        mode_q,
   output logic [LANE_W-1:0] val_q
);

   logic hit;

   assign hit = cfg_we && (cfg_lane == IDX_W'(LANE_ID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         val_q  <= '0;
      end else if (hit) begin
         mode_q <= cfg_mode;
         val_q  <= cfg_wdata;
      end
   end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 48,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pio_lane_io.sv
module pio_lane_io
   import pio_pkg::*;
#(
   parameter int LANE_W     = 8,
   parameter bit RD_SRC_PIN = 1'b1
) (
   input  lane_mode_t        mode,
   input  logic [LANE_W-1:0] val,
   input  logic              ext_tri,
   input  logic [LANE_W-1:0] pin_sync,
   output logic [LANE_W-1:0] pad_out,
   output logic [LANE_W-1:0] pad_oe,
   output logic [LANE_W-1:0] rd_byte
);

   logic drive_en;
   logic [LANE_W-1:0] pol_mask;

   assign pol_mask = {LANE_W{mode.act_low}};
   assign drive_en = mode.dir_out & ~(mode.int_tri | ext_tri);
   assign pad_out  = val ^ pol_mask;
   assign pad_oe   = {LANE_W{drive_en}};

   if (RD_SRC_PIN) begin : g_rd_pin
      assign rd_byte = mode.dir_out ? pin_sync : (pin_sync ^ pol_mask);
   end else begin : g_rd_latch
      assign rd_byte = mode.dir_out ? val : (pin_sync ^ pol_mask);
   end

endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int NUM_LANES   = 6,
   parameter int LANE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit RD_SRC_PIN  = 1'b1,
   localparam int IDX_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) + ((2 ** $clog2(NUM_LANES) == NUM_LANES) ? 0 : 0) : 1,
   localparam int BUS_W      = NUM_LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_lane,
   input  logic              cfg_dir_out,
   input  logic              cfg_act_low,
   input  logic              cfg_int_tri,
   input  logic [LANE_W-1:0] cfg_wdata,
   input  logic [NUM_LANES-1:0] ext_tri,
   input  logic [BUS_W-1:0]  pad_in,
   output logic [BUS_W-1:0]  pad_out,
   output logic [BUS_W-1:0]  pad_oe,
   output logic [BUS_W-1:0]  rd_data
);

   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("pio_port: NUM_LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("pio_port: LANE_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_port: SYNC_STAGES must be at least 2");
   end

   lane_mode_t cfg_mode;
   logic [BUS_W-1:0] pin_sync;

   assign cfg_mode = '{dir_out: cfg_dir_out, act_low: cfg_act_low, int_tri: cfg_int_tri};

   pio_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (pin_sync)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      lane_mode_t        mode_q;
      logic [LANE_W-1:0] val_q;

      pio_lane_reg #(
         .LANE_W (LANE_W),
         .IDX_W  (IDX_W),
         .LANE_ID(l)
      ) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .cfg_lane (cfg_lane),
         .cfg_mode (cfg_mode),
         .cfg_wdata(cfg_wdata),
         .mode_q   (mode_q),
         .val_q    (val_q)
      );

      pio_lane_io #(
         .LANE_W    (LANE_W),
         .RD_SRC_PIN(RD_SRC_PIN)
      ) u_io (
         .mode    (mode_q),
         .val     (val_q),
         .ext_tri (ext_tri[l]),
         .pin_sync(pin_sync[l*LANE_W +: LANE_W]),
         .pad_out (pad_out[l*LANE_W +: LANE_W]),
         .pad_oe  (pad_oe[l*LANE_W +: LANE_W]),
         .rd_byte (rd_data[l*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
   parameter int NUM_LANES = 6,
   parameter int LANE_W    = 8,
   parameter int IDX_W     = 3,
   localparam int BUS_W    = NUM_LANES * LANE_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [IDX_W-1:0]     cfg_lane,
   input logic                 cfg_act_low,
   input logic [LANE_W-1:0]    cfg_wdata,
   input logic [NUM_LANES-1:0] ext_tri,
   input logic [BUS_W-1:0]     pad_out,
   input logic [BUS_W-1:0]     pad_oe
);

   logic oor_write;
   assign oor_write = cfg_we && ({1'b0, cfg_lane} >= (IDX_W + 1)'(NUM_LANES));

   AST_RESET_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0)); // R1

   AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      oor_write |=> $stable(pad_out)); // R9

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
      AST_EXT_TRI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
         ext_tri[l] |-> (pad_oe[l*LANE_W +: LANE_W] == '0)); // R5

      AST_OE_WHOLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(pad_oe[l*LANE_W +: LANE_W]) == 0) ||
         ($countones(pad_oe[l*LANE_W +: LANE_W]) == LANE_W)); // R3

      AST_WRITE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && ({1'b0, cfg_lane} == (IDX_W + 1)'(l))) |=>
         (pad_out[l*LANE_W +: LANE_W] ==
          ($past(cfg_act_low) ? ~$past(cfg_wdata) : $past(cfg_wdata)))); // R2
   end

endmodule

bind pio_port pio_port_chk #(
   .NUM_LANES(NUM_LANES),
   .LANE_W   (LANE_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_lane   (cfg_lane),
   .cfg_act_low(cfg_act_low),
   .cfg_wdata  (cfg_wdata),
   .ext_tri    (ext_tri),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe)
);

// File: tb/pio_port_tb.sv
module pio_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 6;
   localparam int BW = NL * 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [2:0]    cfg_lane;
   logic          cfg_dir_out, cfg_act_low, cfg_int_tri;
   logic [7:0]    cfg_wdata;
   logic [NL-1:0] ext_tri;
   logic [BW-1:0] pad_in, pad_out, pad_oe, rd_data;
   logic [BW-1:0] far_en, far_val, pin;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [NL-1:0] m_dir, m_low, m_tri;
   logic [7:0]    m_val [NL];

   always #(CLK_PERIOD / 2) clk = ~clk;

   // pins: the block drives when enabled, otherwise far side or pull-up
   assign pin    = (pad_oe & pad_out) | (~pad_oe & far_en & far_val) | (~pad_oe & ~far_en);
   assign pad_in = pin;

   pio_port u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_lane   (cfg_lane),
      .cfg_dir_out(cfg_dir_out),
      .cfg_act_low(cfg_act_low),
      .cfg_int_tri(cfg_int_tri),
      .cfg_wdata  (cfg_wdata),
      .ext_tri    (ext_tri),
      .pad_in     (pad_in),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .rd_data    (rd_data)
   );

   function automatic logic [BW-1:0] exp_oe();
      logic [BW-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*8 +: 8] = (m_dir[l] && !m_tri[l] && !ext_tri[l]) ? 8'hFF : 8'h00;
      return r;
   endfunction

   function automatic logic [BW-1:0] exp_out();
      logic [BW-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*8 +: 8] = m_low[l] ? ~m_val[l] : m_val[l];
      return r;
   endfunction

   function automatic logic [BW-1:0] exp_rd(input logic [BW-1:0] p);
      logic [BW-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*8 +: 8] = (!m_dir[l] && m_low[l]) ? ~p[l*8 +: 8] : p[l*8 +: 8];
      return r;
   endfunction

   task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic write_lane(input int lane, input bit dir, input bit low, input bit tri_i,
                             input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lane = 3'(lane);
      cfg_dir_out = dir; cfg_act_low = low; cfg_int_tri = tri_i; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (lane < NL) begin
         m_dir[lane] = dir; m_low[lane] = low; m_tri[lane] = tri_i; m_val[lane] = v;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [BW-1:0] snap_oe, snap_out;
      void'($urandom(32'd4801));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_lane = '0; cfg_dir_out = 1'b0;
      cfg_act_low = 1'b0; cfg_int_tri = 1'b0; cfg_wdata = '0;
      ext_tri = '0; far_en = '0; far_val = '0;
      m_dir = '0; m_low = '0; m_tri = '1;
      for (int l = 0; l < NL; l++) m_val[l] = 8'h00;
      repeat (3) @(negedge clk);
      check("R1 oe in reset", pad_oe, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 oe after reset", pad_oe, '0);
      check("R1 rd pulled up", rd_data, '1);

      // R8: pin change reaches the read word after exactly two edges
      far_en[7:0] = 8'hFF; far_val[7:0] = 8'h5A;
      @(negedge clk);
      check("R8 one edge old", {40'h0, rd_data[7:0]}, {40'h0, 8'hFF});
      @(negedge clk);
      check("R8 two edges new", {40'h0, rd_data[7:0]}, {40'h0, 8'h5A});

      // R7: active-low input lane inverts
      write_lane(0, 1'b0, 1'b1, 1'b0, 8'h00);
      check("R7 active-low input", {40'h0, rd_data[7:0]}, {40'h0, 8'hA5});

      // R2: not before the edge; R3 drive
      @(negedge clk);
      cfg_we = 1'b1; cfg_lane = 3'd1; cfg_dir_out = 1'b1; cfg_act_low = 1'b0;
      cfg_int_tri = 1'b0; cfg_wdata = 8'hA5;
      #1;
      check("R2 before edge", pad_oe, '0);
      @(negedge clk);
      cfg_we = 1'b0;
      m_dir[1] = 1'b1; m_low[1] = 1'b0; m_tri[1] = 1'b0; m_val[1] = 8'hA5;
      check("R3 drive oe", pad_oe, exp_oe());
      check("R3 drive out", pad_out, exp_out());

      // R5: external tri-state acts without a clock edge
      @(negedge clk);
      ext_tri[1] = 1'b1;
      #1;
      check("R5 ext tri same cycle", pad_oe, '0);
      ext_tri[1] = 1'b0;
      #1;
      check("R5 ext tri released", pad_oe, exp_oe());

      // R4: internal tri-state on an output lane, active low
      write_lane(1, 1'b1, 1'b1, 1'b1, 8'h3C);
      check("R4 int tri oe", pad_oe, exp_oe());
      check("R3 active-low out", pad_out, exp_out());
      repeat (2) @(negedge clk);
      check("R4 tri lane pulled up", {40'h0, rd_data[15:8]}, {40'h0, 8'hFF});

      // R9: lane numbers with no lane behind them
      write_lane(2, 1'b1, 1'b0, 1'b0, 8'h11);
      snap_oe = pad_oe; snap_out = pad_out;
      write_lane(6, 1'b1, 1'b1, 1'b0, 8'hEE);
      check("R9 lane 6 oe", pad_oe, snap_oe);
      check("R9 lane 6 out", pad_out, snap_out);
      write_lane(7, 1'b0, 1'b1, 1'b1, 8'h77);
      check("R9 lane 7 oe", pad_oe, snap_oe);
      check("R9 lane 7 out", pad_out, snap_out);

      // random mix: R2 R3 R4 R6 R7
      for (int it = 0; it < 300; it++) begin
         @(negedge clk);
         ext_tri = NL'($urandom);
         far_en  = {$urandom, $urandom};
         far_val = {$urandom, $urandom};
         cfg_we = 1'b1; cfg_lane = 3'($urandom_range(0, 7));
         cfg_dir_out = 1'($urandom); cfg_act_low = 1'($urandom);
         cfg_int_tri = ($urandom_range(0, 3) == 0); cfg_wdata = 8'($urandom);
         if (cfg_lane < 3'(NL)) begin
            m_dir[cfg_lane] = cfg_dir_out; m_low[cfg_lane] = cfg_act_low;
            m_tri[cfg_lane] = cfg_int_tri; m_val[cfg_lane] = cfg_wdata;
         end
         @(negedge clk);
         cfg_we = 1'b0;
         check("R2 R3 R4 R6 oe", pad_oe, exp_oe());
         check("R2 R3 out", pad_out, exp_out());
         repeat (2) @(negedge clk);
         check("R7 R8 read", rd_data, exp_rd(pin));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule